// File: doc/BRIEF.md
# Scaled Integer Add, Subtract and Compare Unit

This block is the purely combinational integer arithmetic slice of a RISC execution stage. It takes two 64-bit operands, where the second operand has already been chosen between a register value and a literal, together with a 7-bit function code. It returns a 64-bit result and a flag that requests an integer-overflow trap. Register-file access, operand selection and the delivery of the trap belong to the surrounding pipeline.

The unit covers 32-bit (longword) and 64-bit (quadword) addition and subtraction. Either form can first scale operand A by 4 or 8, which supports address arithmetic over arrays of words. Longword results are sign-extended from bit 31. Trapping variants of the unscaled add and subtract raise the overflow flag on signed overflow. The unit also provides five compares that yield 0 or 1, and a byte-parallel unsigned compare that yields an 8-bit mask. Any other function code is reported as illegal.

Top module: `scaled_arith_unit`

## Requirements
- R1: Add codes give (A shifted left by s) + B, with s = 0, 2 or 3. The codes are 0x00, 0x02 (s=2) and 0x12 (s=3) for longword, and 0x20, 0x22 (s=2) and 0x32 (s=3) for quadword.
- R2: Subtract codes give (A shifted left by s) - B. The codes are 0x09, 0x0b (s=2) and 0x1b (s=3) for longword, and 0x29, 0x2b (s=2) and 0x3b (s=3) for quadword.
- R3: Longword operations use only bits 31:0 of each operand. Result bits 63:32 are copies of result bit 31.
- R4: Trapping adds 0x40 (longword) and 0x60 (quadword) return the same value as 0x00 and 0x20. The overflow flag is high exactly when both operands have the same sign and the result sign differs from A. The sign is bit 31 for longword and bit 63 for quadword.
- R5: Trapping subtracts 0x49 (longword) and 0x69 (quadword) return the same value as 0x09 and 0x29. The overflow flag is high exactly when the operand signs differ and the result sign differs from A.
- R6: For every code other than 0x40, 0x60, 0x49 and 0x69 the overflow flag is low.
- R7: Compares return 1 when true and 0 otherwise, with bits 63:1 zero. The codes are 0x2d (equal), 0x6d (signed less-or-equal), 0x4d (signed less-than), 0x3d (unsigned less-or-equal) and 0x1d (unsigned less-than).
- R8: Code 0x0f sets result bit i (i = 0..7) when byte i of A (bits 8i+7:8i) is unsigned greater than or equal to byte i of B. Bits 63:8 are zero.
- R9: Any code not listed above gives a zero result, drives the illegal output high and keeps the overflow flag low. The illegal output is low for every listed code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a_i | input | 64 | Operand A |
| opnd_b_i | input | 64 | Operand B (register or literal, already selected) |
| func_i | input | 7 | Function code |
| result_o | output | 64 | Operation result |
| ovf_trap_o | output | 1 | Signed overflow on a trapping variant |
| illegal_o | output | 1 | Function code not recognised |

## Verification
The bound checker watches, at all times, the shape properties that do not depend on the arithmetic values:
- longword results are sign-extended;
- compare results are boolean;
- the byte mask leaves the upper bits clear;
- the overflow flag stays low on non-trapping codes;
- an illegal code yields zero.

Whether sums, differences, scaled values, compare outcomes and overflow decisions are numerically correct can only be shown by the bench. It sweeps every one of the 128 function codes against all pairs of a set of sign-boundary and byte-pattern operands, and compares each output with an arithmetic model that uses wider signed integers.

// File: rtl/sau_pkg.sv
package sau_pkg;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_CMP   = 2'd1,
    CLS_BYTE  = 2'd2,
    CLS_ILL   = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    CK_EQ  = 3'd0,
    CK_SLE = 3'd1,
    CK_SLT = 3'd2,
    CK_ULE = 3'd3,
    CK_ULT = 3'd4
  } cmp_kind_e;

  typedef struct packed {
    op_class_e  cls;
    logic       is_long;
    logic       is_sub;
    logic [1:0] shamt;
    logic       trap;
    cmp_kind_e  cmp;
  } ctrl_t;

endpackage

// File: rtl/sau_decode.sv
module sau_decode
  import sau_pkg::*;
#(
  parameter int FUNC_W = 7
) (
  input  logic [FUNC_W-1:0] func_i,
  output ctrl_t             ctrl_o
);

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.cls     = CLS_ILL;
    ctrl_o.cmp     = CK_EQ;
    case (func_i)
      7'h00: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_long = 1'b1; end
      7'h02: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_long = 1'b1; ctrl_o.shamt = 2'd2; end
      7'h12: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_long = 1'b1; ctrl_o.shamt = 2'd3; end
      7'h20: begin ctrl_o.cls = CLS_ARITH; end
      7'h22: begin ctrl_o.cls = CLS_ARITH; ctrl_o.shamt = 2'd2; end
      7'h32: begin ctrl_o.cls = CLS_ARITH; ctrl_o.shamt = 2'd3; end
      7'h09: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_long = 1'b1; ctrl_o.is_sub = 1'b1; end
      7'h0b: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_long = 1'b1; ctrl_o.is_sub = 1'b1; ctrl_o.shamt = 2'd2; end
      7'h1b: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_long = 1'b1; ctrl_o.is_sub = 1'b1; ctrl_o.shamt = 2'd3; end
      7'h29: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_sub = 1'b1; end
      7'h2b: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_sub = 1'b1; ctrl_o.shamt = 2'd2; end
      7'h3b: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_sub = 1'b1; ctrl_o.shamt = 2'd3; end
      7'h40: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_long = 1'b1; ctrl_o.trap = 1'b1; end
      7'h60: begin ctrl_o.cls = CLS_ARITH; ctrl_o.trap = 1'b1; end
      7'h49: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_long = 1'b1; ctrl_o.is_sub = 1'b1; ctrl_o.trap = 1'b1; end
      7'h69: begin ctrl_o.cls = CLS_ARITH; ctrl_o.is_sub = 1'b1; ctrl_o.trap = 1'b1; end
      7'h2d: begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CK_EQ;  end
      7'h6d: begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CK_SLE; end
      7'h4d: begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CK_SLT; end
      7'h3d: begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CK_ULE; end
      7'h1d: begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CK_ULT; end
      7'h0f: begin ctrl_o.cls = CLS_BYTE; end
      default: ctrl_o.cls = CLS_ILL;
    endcase
  end

endmodule

// File: rtl/sau_addsub.sv
module sau_addsub #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            is_long_i,
  input  logic            is_sub_i,
  input  logic [1:0]      shamt_i,
  input  logic            trap_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] a_sc;
  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] sum;
  logic            sgn_a, sgn_b, sgn_r;

  always_comb begin
    a_sc  = a_i << shamt_i;
    b_eff = is_sub_i ? ~b_i : b_i;
    sum   = a_sc + b_eff + {{(XLEN-1){1'b0}}, is_sub_i};
    res_o = is_long_i ? {{HALF{sum[HALF-1]}}, sum[HALF-1:0]} : sum;
    sgn_a = is_long_i ? a_sc[HALF-1] : a_sc[XLEN-1];
    sgn_b = is_long_i ? b_i[HALF-1]  : b_i[XLEN-1];
    sgn_r = is_long_i ? sum[HALF-1]  : sum[XLEN-1];
    ovf_o = trap_i & (is_sub_i ? (sgn_a != sgn_b) : (sgn_a == sgn_b)) & (sgn_r != sgn_a);
  end

endmodule

// File: rtl/sau_cmp.sv
module sau_cmp
  import sau_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  cmp_kind_e       kind_i,
  output logic            hit_o
);

  logic eq, slt, ult;

  always_comb begin
    eq  = (a_i == b_i);
    slt = ($signed(a_i) < $signed(b_i));
    ult = (a_i < b_i);
    case (kind_i)
      CK_EQ:   hit_o = eq;
      CK_SLE:  hit_o = slt | eq;
      CK_SLT:  hit_o = slt;
      CK_ULE:  hit_o = ult | eq;
      CK_ULT:  hit_o = ult;
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sau_bytecmp.sv
module sau_bytecmp #(
  parameter int XLEN  = 64,
  parameter int LANES = XLEN / 8
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  output logic [LANES-1:0] mask_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_o[g] = (a_i[8*g +: 8] >= b_i[8*g +: 8]);
  end

endmodule

// File: rtl/scaled_arith_unit.sv
module scaled_arith_unit
  import sau_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int FUNC_W = 7
) (
  input  logic [XLEN-1:0]   opnd_a_i,
  input  logic [XLEN-1:0]   opnd_b_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [XLEN-1:0]   result_o,
  output logic              ovf_trap_o,
  output logic              illegal_o
);

  localparam int LANES = XLEN / 8;

  ctrl_t            ctrl;
  logic [XLEN-1:0]  arith_res;
  logic             arith_ovf;
  logic             cmp_hit;
  logic [LANES-1:0] byte_mask;

  sau_decode #(.FUNC_W(FUNC_W)) u_dec (
    .func_i (func_i),
    .ctrl_o (ctrl)
  );

  sau_addsub #(.XLEN(XLEN)) u_add (
    .a_i       (opnd_a_i),
    .b_i       (opnd_b_i),
    .is_long_i (ctrl.is_long),
    .is_sub_i  (ctrl.is_sub),
    .shamt_i   (ctrl.shamt),
    .trap_i    (ctrl.trap),
    .res_o     (arith_res),
    .ovf_o     (arith_ovf)
  );

  sau_cmp #(.XLEN(XLEN)) u_cmp (
    .a_i    (opnd_a_i),
    .b_i    (opnd_b_i),
    .kind_i (ctrl.cmp),
    .hit_o  (cmp_hit)
  );

  sau_bytecmp #(.XLEN(XLEN), .LANES(LANES)) u_byte (
    .a_i    (opnd_a_i),
    .b_i    (opnd_b_i),
    .mask_o (byte_mask)
  );

  always_comb begin
    result_o   = '0;
    ovf_trap_o = 1'b0;
    illegal_o  = 1'b0;
    case (ctrl.cls)
      CLS_ARITH: begin
        result_o   = arith_res;
        ovf_trap_o = arith_ovf;
      end
      CLS_CMP:  result_o = {{(XLEN-1){1'b0}}, cmp_hit};
      CLS_BYTE: result_o = {{(XLEN-LANES){1'b0}}, byte_mask};
      default:  illegal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/scaled_arith_unit_chk.sv
module scaled_arith_unit_chk (
  input logic [6:0]  func_i,
  input logic [63:0] result_o,
  input logic        ovf_trap_o,
  input logic        illegal_o
);

  logic long_code, trap_code, cmp_code;

  always_comb begin
    long_code = (func_i == 7'h00) || (func_i == 7'h02) || (func_i == 7'h12) ||
                (func_i == 7'h09) || (func_i == 7'h0b) || (func_i == 7'h1b) ||
                (func_i == 7'h40) || (func_i == 7'h49);
    trap_code = (func_i == 7'h40) || (func_i == 7'h60) ||
                (func_i == 7'h49) || (func_i == 7'h69);
    cmp_code  = (func_i == 7'h2d) || (func_i == 7'h6d) || (func_i == 7'h4d) ||
                (func_i == 7'h3d) || (func_i == 7'h1d);

    // R3
    long_sext_chk: assert (!long_code || (result_o[63:32] == {32{result_o[31]}}))
      else $error("longword result not sign-extended");
    // R6
    no_overflow_chk: assert (trap_code || !ovf_trap_o)
      else $error("overflow raised on non-trapping code");
    // R7
    cmp_bool_chk: assert (!cmp_code || (result_o[63:1] == 63'd0))
      else $error("compare result not boolean");
    // R8
    bytemask_upper_chk: assert ((func_i != 7'h0f) || (result_o[63:8] == 56'd0))
      else $error("byte compare upper bits set");
    // R9
    illegal_zero_chk: assert (!illegal_o || ((result_o == 64'd0) && !ovf_trap_o))
      else $error("illegal code produced data or overflow");
    // R9
    legal_flag_chk: assert (!(long_code || cmp_code || trap_code || func_i == 7'h0f) || !illegal_o)
      else $error("listed code flagged illegal");
  end

endmodule

bind scaled_arith_unit scaled_arith_unit_chk u_chk (
  .func_i     (func_i),
  .result_o   (result_o),
  .ovf_trap_o (ovf_trap_o),
  .illegal_o  (illegal_o)
);

// File: tb/scaled_arith_unit_tb.sv
module scaled_arith_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic [63:0] a, b;
  logic [6:0]  func;
  logic [63:0] result;
  logic        ovf, ill;
  int          n_checks;
  int          n_errors;
  bit          done;

  scaled_arith_unit dut_i (
    .opnd_a_i   (a),
    .opnd_b_i   (b),
    .func_i     (func),
    .result_o   (result),
    .ovf_trap_o (ovf),
    .illegal_o  (ill)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] pats [16];
  initial begin
    pats[0]  = 64'h0;
    pats[1]  = 64'h1;
    pats[2]  = 64'hffff_ffff_ffff_ffff;
    pats[3]  = 64'h0000_0000_7fff_ffff;
    pats[4]  = 64'h0000_0000_8000_0000;
    pats[5]  = 64'h7fff_ffff_ffff_ffff;
    pats[6]  = 64'h8000_0000_0000_0000;
    pats[7]  = 64'h0123_4567_89ab_cdef;
    pats[8]  = 64'hfedc_ba98_7654_3210;
    pats[9]  = 64'h0000_0000_4000_0000;
    pats[10] = 64'h3fff_ffff_ffff_ffff;
    pats[11] = 64'h00ff_00ff_8001_7f80;
    pats[12] = 64'h0000_0000_ffff_ffff;
    pats[13] = 64'h2;
    pats[14] = 64'hc000_0000_0000_0000;
    pats[15] = 64'h5555_aaaa_5555_aaaa;
  end

  function automatic void model(input logic [6:0] f, input logic [63:0] x, input logic [63:0] y,
                                output logic [63:0] r, output logic o, output logic il,
                                output string tag);
    int          sh;
    int          lr;
    longint      wl;
    logic [64:0] wq;
    r = '0; o = 1'b0; il = 1'b0; tag = "R9"; sh = 0;
    case (f)
      7'h02, 7'h22, 7'h0b, 7'h2b: sh = 2;
      7'h12, 7'h32, 7'h1b, 7'h3b: sh = 3;
      default: sh = 0;
    endcase
    case (f)
      7'h00, 7'h02, 7'h12, 7'h40: begin
        lr = int'(x[31:0] << sh) + int'(y[31:0]);
        r  = 64'(longint'(lr));
        wl = longint'(int'(x[31:0])) + longint'(int'(y[31:0]));
        o  = (f == 7'h40) && (wl != longint'(lr));
        tag = (f == 7'h40) ? "R4" : "R1/R3";
      end
      7'h09, 7'h0b, 7'h1b, 7'h49: begin
        lr = int'(x[31:0] << sh) - int'(y[31:0]);
        r  = 64'(longint'(lr));
        wl = longint'(int'(x[31:0])) - longint'(int'(y[31:0]));
        o  = (f == 7'h49) && (wl != longint'(lr));
        tag = (f == 7'h49) ? "R5" : "R2/R3";
      end
      7'h20, 7'h22, 7'h32, 7'h60: begin
        r  = (x << sh) + y;
        wq = {x[63], x} + {y[63], y};
        o  = (f == 7'h60) && (wq[64] != wq[63]);
        tag = (f == 7'h60) ? "R4" : "R1";
      end
      7'h29, 7'h2b, 7'h3b, 7'h69: begin
        r  = (x << sh) - y;
        wq = {x[63], x} - {y[63], y};
        o  = (f == 7'h69) && (wq[64] != wq[63]);
        tag = (f == 7'h69) ? "R5" : "R2";
      end
      7'h2d: begin r = 64'(x == y); tag = "R7"; end
      7'h6d: begin r = 64'($signed(x) <= $signed(y)); tag = "R7"; end
      7'h4d: begin r = 64'($signed(x) < $signed(y)); tag = "R7"; end
      7'h3d: begin r = 64'(x <= y); tag = "R7"; end
      7'h1d: begin r = 64'(x < y); tag = "R7"; end
      7'h0f: begin
        for (int i = 0; i < 8; i++) r[i] = (x[8*i +: 8] >= y[8*i +: 8]);
        tag = "R8";
      end
      default: il = 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] er, input logic eo, input logic ei);
    n_checks++;
    if (result !== er || ovf !== eo || ill !== ei) begin
      n_errors++;
      $display("FAIL %s func=%02h a=%h b=%h actual r=%h ovf=%b ill=%b expected r=%h ovf=%b ill=%b",
               tag, func, a, b, result, ovf, ill, er, eo, ei);
    end
  endtask

  initial begin
    logic [63:0] er;
    logic        eo, ei;
    string       tag;
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0; a = '0; b = '0; func = 7'h00;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset-state check: zero operands, add code
    check("R1", 64'd0, 1'b0, 1'b0);
    // Sweep: every function code (R1..R9) against every operand pair
    for (int f = 0; f < 128; f++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          @(posedge clk);
          func = 7'(f); a = pats[i]; b = pats[j];
          @(negedge clk);
          model(func, a, b, er, eo, ei, tag);
          check(tag, er, eo, ei);
        end
      end
    end
    // R6 scaled longword add that wraps must not raise overflow
    @(posedge clk); func = 7'h12; a = 64'h0000_0000_2000_0000; b = 64'h0;
    @(negedge clk); check("R6", 64'h0, 1'b0, 1'b0);
    // R8 byte compare with equal bytes in every lane
    @(posedge clk); func = 7'h0f; a = 64'h1122_3344_5566_7788; b = a;
    @(negedge clk); check("R8", 64'hff, 1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule